// File: doc/BRIEF.md
# Quad DAC Command Register Bank

This block is the digital front end of a four-channel digital-to-analog converter. A host shifts 24-bit command words into it over a four-wire serial port. Each word carries a read/write flag, a register selector, a channel address and a 16-bit payload. The bank keeps a data code, a coarse gain word, a fine gain word and an offset word for each of the four channels. It also keeps one function register, whose bit 0 chooses between offset-binary and twos-complement coding. The four data codes are driven in parallel to the converter core.

A clear returns every channel's code to the clear value of the active coding. Either a falling edge on the clear pin or a dedicated command word can start it. The code then stays at that value until the host writes that channel again. A read command loads the addressed register into a transmit shifter, and the host clocks it out during its next frame. The serial port and the clear pin are asynchronous to the system clock and are sampled through synchronizers.

Top module: `quad_dac_regbank`

## Requirements
- R1: A frame is taken only when exactly 24 bits were clocked while the select line was low, and bit 22 of the frame is 0. A frame that has bit 22 set changes no register and no output.
- R2: A write (bit 23 = 0) with selector 3'b010 (bits 21:19) and channel field 0..3 (bits 18:16) loads bits 15:0 into that channel's code. Channel 0 sits in `dac_code[15:0]`, and the other channels do not change.
- R3: Channel field 3'b100 applies a register write to all four channels at once.
- R4: Selector 3'b000 with channel field 3'b000 writes the function register. Its bit 0 picks the coding: 0 is offset binary and 1 is twos complement. The coding is 0 after reset.
- R5: A falling edge on the synchronized clear pin sets every code to the clear value of the current coding. That value is 16'h0000 for both codings by default. The codes hold that value after the pin rises until a channel is written.
- R6: If the clear pin is low when reset is released, all codes take the clear value.
- R7: A frame whose upper byte is 8'h04 runs the same clear as the pin, whatever its low 16 bits hold.
- R8: An accepted read frame (bit 23 = 1) makes the addressed register appear on `spi_miso` during the next frame, MSB first, as {8'h00, value}. Selectors 3'b011, 3'b100 and 3'b101 give coarse gain, fine gain and offset. Selector 3'b000 gives {15'b0, coding}. A read with channel field 3'b100 returns channel 0.
- R9: After reset every code is 16'h8000, and every gain and offset register is 0.
- R10: If a clear edge and an accepted frame land in the same cycle, the clear wins and the frame is dropped.
- R11: Frames of 23 or 25 bits change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock; input sampled on its rising edge, output shifted on its falling edge |
| spi_cs_n | input | 1 | Active-low frame select; its rising edge ends a frame |
| spi_mosi | input | 1 | Serial command data, MSB first |
| spi_miso | output | 1 | Serial readback data, MSB first |
| clr_n | input | 1 | Asynchronous active-low clear pin, acting on its falling edge |
| dac_code | output | 64 | Four 16-bit channel codes, channel 0 in the low bits |

## Verification
The clear edge and the end of a frame can be accepted in the same clock cycle. Both come through synchronizers of equal depth. The bench provokes this by raising the select line and dropping the clear pin on the same clock edge, at the end of a frame that writes a fresh value to one channel. The result is judged at the output word. All four codes must read the clear value, and the written value must not appear, before or after the clear pin is released.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  localparam int FRAME_W  = 24;
  localparam int FIELD_DW = 16;

  typedef enum logic [2:0] {
    SEL_FUNC  = 3'b000,
    SEL_DATA  = 3'b010,
    SEL_CGAIN = 3'b011,
    SEL_FGAIN = 3'b100,
    SEL_OFFS  = 3'b101
  } reg_sel_e;

  localparam logic [2:0] ADDR_ALL  = 3'b100;
  localparam logic [2:0] ADDR_FUNC = 3'b000;

  typedef struct packed {
    logic                rd;
    logic                zero;
    logic [2:0]          sel;
    logic [2:0]          addr;
    logic [FIELD_DW-1:0] data;
  } frame_t;

endpackage

// File: rtl/qdac_spi_port.sv
module qdac_spi_port #(
  parameter int FW = 24,
  parameter int CW = $clog2(FW + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  input  logic          tx_load,
  input  logic [FW-1:0] tx_word,
  output logic          miso,
  output logic          frame_end,
  output logic          frame_ok,
  output logic [FW-1:0] frame
);

  logic [2:0]    sclk_q;
  logic [2:0]    cs_q;
  logic [1:0]    mosi_q;
  logic [FW-1:0] rx_sh;
  logic [FW-1:0] tx_sh;
  logic [CW-1:0] cnt;
  logic          s_rise;
  logic          s_fall;
  logic          cs_low;
  logic          cs_rise;

  assign s_rise  = sclk_q[1] & ~sclk_q[2];
  assign s_fall  = ~sclk_q[1] & sclk_q[2];
  assign cs_low  = ~cs_q[1];
  assign cs_rise = cs_q[1] & ~cs_q[2];

  // input synchronizers, all the same depth
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  // receive shifter and saturating bit counter
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh     <= '0;
      cnt       <= '0;
      frame_end <= 1'b0;
      frame_ok  <= 1'b0;
      frame     <= '0;
    end else begin
      frame_end <= cs_rise;
      frame_ok  <= cs_rise && (cnt == CW'(FW));
      if (cs_rise) begin
        frame <= rx_sh;
        cnt   <= '0;
      end else if (cs_low && s_rise) begin
        rx_sh <= {rx_sh[FW-2:0], mosi_q[1]};
        if (cnt <= CW'(FW)) cnt <= cnt + 1'b1;
      end
    end
  end

  // transmit shifter
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
    end else if (tx_load) begin
      tx_sh <= tx_word;
    end else if (cs_low && s_fall) begin
      tx_sh <= {tx_sh[FW-2:0], 1'b0};
    end
  end

  assign miso = tx_sh[FW-1];

endmodule

// File: rtl/qdac_clr_detect.sv
module qdac_clr_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int QW          = SYNC_STAGES + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  output logic clr_evt
);

  // reset to high so a pin held low at reset release reads as a falling edge
  logic [QW-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= '1;
      clr_evt <= 1'b0;
    end else begin
      q       <= {q[QW-2:0], clr_n};
      clr_evt <= q[QW-1] & ~q[QW-2];
    end
  end

endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
  import qdac_pkg::*;
#(
  parameter int          NCH      = 4,
  parameter int          DW       = 16,
  parameter int          FW       = 24,
  parameter logic [15:0] RST_CODE = 16'h8000,
  parameter logic [15:0] CLR_OB   = 16'h0000,
  parameter logic [15:0] CLR_TC   = 16'h0000,
  parameter int          CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_end,
  input  logic              frame_ok,
  input  logic [FW-1:0]     frame,
  input  logic              clr_evt,
  output logic              coding,
  output logic [NCH*DW-1:0] codes,
  output logic              rd_load,
  output logic [FW-1:0]     rd_word
);

  frame_t          f;
  logic [DW-1:0]   data_r [NCH];
  logic [DW-1:0]   cg_r   [NCH];
  logic [DW-1:0]   fg_r   [NCH];
  logic [DW-1:0]   of_r   [NCH];
  logic            coding_r;
  logic            accept;
  logic            sw_clr;
  logic            do_clr;
  logic            wr_en;
  logic [NCH-1:0]  hit;
  logic [CHW-1:0]  rch;
  logic            rvalid;
  logic [DW-1:0]   rd_val;
  logic [DW-1:0]   clr_val;

  assign f       = frame_t'(frame);
  assign accept  = frame_end && frame_ok && !f.zero && !clr_evt;
  assign sw_clr  = accept && !f.rd && (f.sel == SEL_FUNC) && (f.addr == ADDR_ALL);
  assign do_clr  = clr_evt || sw_clr;
  assign wr_en   = accept && !f.rd && !sw_clr;
  assign clr_val = coding_r ? CLR_TC : CLR_OB;

  for (genvar g = 0; g < NCH; g++) begin : g_hit
    assign hit[g] = (f.addr == ADDR_ALL) || (f.addr == 3'(g));
    assign codes[g*DW +: DW] = data_r[g];
  end

  // read selection; broadcast address reads channel 0
  assign rch    = (f.addr == ADDR_ALL) ? '0 : f.addr[CHW-1:0];
  assign rvalid = (f.addr == ADDR_ALL) || (int'(f.addr) < NCH);

  always_comb begin
    rd_val = '0;
    case (f.sel)
      SEL_FUNC:  rd_val = {{(DW-1){1'b0}}, coding_r};
      SEL_DATA:  if (rvalid) rd_val = data_r[rch];
      SEL_CGAIN: if (rvalid) rd_val = cg_r[rch];
      SEL_FGAIN: if (rvalid) rd_val = fg_r[rch];
      SEL_OFFS:  if (rvalid) rd_val = of_r[rch];
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      coding_r <= 1'b0;
      rd_load  <= 1'b0;
      rd_word  <= '0;
      for (int i = 0; i < NCH; i++) begin
        data_r[i] <= RST_CODE;
        cg_r[i]   <= '0;
        fg_r[i]   <= '0;
        of_r[i]   <= '0;
      end
    end else begin
      rd_load <= accept;
      rd_word <= (accept && f.rd) ? {{(FW-DW){1'b0}}, rd_val} : '0;
      if (do_clr) begin
        for (int i = 0; i < NCH; i++) data_r[i] <= clr_val;
      end
      if (wr_en) begin
        if (f.sel == SEL_FUNC && f.addr == ADDR_FUNC) coding_r <= f.data[0];
        for (int i = 0; i < NCH; i++) begin
          if (hit[i]) begin
            case (f.sel)
              SEL_DATA:  data_r[i] <= f.data;
              SEL_CGAIN: cg_r[i]   <= f.data;
              SEL_FGAIN: fg_r[i]   <= f.data;
              SEL_OFFS:  of_r[i]   <= f.data;
              default:   ;
            endcase
          end
        end
      end
    end
  end

  assign coding = coding_r;

endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
  import qdac_pkg::*;
#(
  parameter int          NCH      = 4,
  parameter int          DW       = 16,
  parameter logic [15:0] RST_CODE = 16'h8000,
  parameter logic [15:0] CLR_OB   = 16'h0000,
  parameter logic [15:0] CLR_TC   = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              clr_n,
  output logic [NCH*DW-1:0] dac_code
);

  localparam int FW = FRAME_W;

  logic          frame_end;
  logic          frame_ok;
  logic [FW-1:0] frame;
  logic          clr_evt;
  logic          coding;
  logic          rd_load;
  logic [FW-1:0] rd_word;

  qdac_spi_port #(.FW(FW)) port_i (
    .clk       (clk),
    .rst       (rst),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .tx_load   (rd_load),
    .tx_word   (rd_word),
    .miso      (spi_miso),
    .frame_end (frame_end),
    .frame_ok  (frame_ok),
    .frame     (frame)
  );

  qdac_clr_detect #(.SYNC_STAGES(2)) clr_i (
    .clk     (clk),
    .rst     (rst),
    .clr_n   (clr_n),
    .clr_evt (clr_evt)
  );

  qdac_regs #(
    .NCH(NCH), .DW(DW), .FW(FW),
    .RST_CODE(RST_CODE), .CLR_OB(CLR_OB), .CLR_TC(CLR_TC)
  ) regs_i (
    .clk       (clk),
    .rst       (rst),
    .frame_end (frame_end),
    .frame_ok  (frame_ok),
    .frame     (frame),
    .clr_evt   (clr_evt),
    .coding    (coding),
    .codes     (dac_code),
    .rd_load   (rd_load),
    .rd_word   (rd_word)
  );

endmodule

// File: rtl/qdac_chk.sv
module qdac_chk #(
  parameter int          NCH      = 4,
  parameter int          DW       = 16,
  parameter logic [15:0] RST_CODE = 16'h8000,
  parameter logic [15:0] CLR_OB   = 16'h0000,
  parameter logic [15:0] CLR_TC   = 16'h0000
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_evt,
  input logic              frame_end,
  input logic              frame_ok,
  input logic              coding,
  input logic [NCH*DW-1:0] dac_code
);

  logic [DW-1:0] cv;
  assign cv = coding ? CLR_TC : CLR_OB;

  // R9: reset state of the codes and the coding bit
  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (dac_code == {NCH{RST_CODE}}) && !coding);

  // R5: a clear edge lands every channel on the clear value
  a_r5_clear_code: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> dac_code == {NCH{$past(cv)}});

  // R10: clear beats a frame ending in the same cycle
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_evt && frame_end && frame_ok |=> (dac_code == {NCH{$past(cv)}}) && $stable(coding));

  // R11: a frame of the wrong length leaves everything alone
  a_r11_bad_len_ignored: assert property (@(posedge clk) disable iff (rst)
    frame_end && !frame_ok && !clr_evt |=> $stable(dac_code) && $stable(coding));

  // R2: codes move only on a frame or a clear
  a_r2_codes_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_end && !clr_evt |=> $stable(dac_code));

  // R4: coding changes only when a frame ends
  a_r4_coding_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(coding));

endmodule

bind quad_dac_regbank qdac_chk #(
  .NCH(NCH), .DW(DW), .RST_CODE(RST_CODE), .CLR_OB(CLR_OB), .CLR_TC(CLR_TC)
) chk_i (.*);

// File: tb/quad_dac_regbank_tb_top.sv
module quad_dac_regbank_tb_top;

  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam int H   = 8;

  typedef struct {
    int          kind;      // 0: codes, 1: readback word
    string       req;
    logic [63:0] exp_codes;
    logic [23:0] exp_rd;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sclk = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        clr_n = 1'b1;
  logic        spi_miso;
  logic [63:0] dac_code;

  item_t       exp_q[$];
  event        item_ev;
  logic [23:0] rd_seen;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  quad_dac_regbank dut_i (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .clr_n(clr_n), .dac_code(dac_code)
  );

  function automatic logic [23:0] mk(input logic rd, input logic [2:0] sel,
                                     input logic [2:0] addr, input logic [15:0] d);
    return {rd, 1'b0, sel, addr, d};
  endfunction

  function automatic logic [63:0] cv4(input logic [15:0] a, input logic [15:0] b,
                                      input logic [15:0] c, input logic [15:0] d);
    return {d, c, b, a};
  endfunction

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(item_ev);
      while (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        n_checks++;
        if (it.kind == 0) begin
          if (dac_code !== it.exp_codes) begin
            n_fail++;
            $display("FAIL %s codes actual=%h expected=%h", it.req, dac_code, it.exp_codes);
          end
        end else begin
          if (rd_seen !== it.exp_rd) begin
            n_fail++;
            $display("FAIL %s readback actual=%h expected=%h", it.req, rd_seen, it.exp_rd);
          end
        end
      end
    end
  end

  task automatic push_codes(input string req, input logic [63:0] e);
    item_t it;
    it.kind = 0; it.req = req; it.exp_codes = e; it.exp_rd = '0;
    exp_q.push_back(it);
    -> item_ev;
    #1;
  endtask

  task automatic push_rd(input string req, input logic [23:0] e);
    item_t it;
    it.kind = 1; it.req = req; it.exp_codes = '0; it.exp_rd = e;
    exp_q.push_back(it);
    -> item_ev;
    #1;
  endtask

  task automatic xfer(input logic [23:0] w, input int nbits, input bit clr_at_end);
    logic [23:0] got;
    got = '0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 24) ? w[23-i] : 1'b0;
      repeat (H) @(negedge clk);
      if (i < 24) got[23-i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (H) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    spi_cs_n = 1'b0 | 1'b1;
    if (clr_at_end) clr_n = 1'b0;
    repeat (12) @(negedge clk);
    rd_seen = got;
  endtask

  task automatic do_reset(input logic clr_level);
    @(negedge clk);
    rst = 1'b1;
    clr_n = clr_level;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  localparam logic [2:0] S_FUNC = 3'b000, S_DATA = 3'b010, S_CG = 3'b011,
                         S_FG = 3'b100, S_OF = 3'b101, S_NONE = 3'b001;

  initial begin
    do_reset(1'b1);
    push_codes("R9 reset codes", {4{16'h8000}});

    xfer(mk(1, S_FG, 3'd1, 16'h0), 24, 0);
    xfer(mk(1, S_NONE, 3'd0, 16'h0), 24, 0);
    push_rd("R9 fine gain reset", 24'h000000);

    xfer(mk(0, S_DATA, 3'd0, 16'h1234), 24, 0);
    push_codes("R2 write ch0", cv4(16'h1234, 16'h8000, 16'h8000, 16'h8000));
    xfer(mk(0, S_DATA, 3'd2, 16'hBEEF), 24, 0);
    push_codes("R2 write ch2", cv4(16'h1234, 16'h8000, 16'hBEEF, 16'h8000));

    xfer(mk(0, S_DATA, 3'd4, 16'h5555), 24, 0);
    push_codes("R3 broadcast data", {4{16'h5555}});
    xfer(mk(0, S_DATA, 3'd1, 16'h6666), 24, 0);
    push_codes("R2 write ch1", cv4(16'h5555, 16'h6666, 16'h5555, 16'h5555));

    xfer(mk(0, S_CG, 3'd1, 16'h0002), 24, 0);
    xfer(mk(0, S_FG, 3'd3, 16'h00A5), 24, 0);
    xfer(mk(0, S_OF, 3'd0, 16'h7F00), 24, 0);
    xfer(mk(1, S_CG, 3'd1, 16'h0), 24, 0);
    xfer(mk(1, S_FG, 3'd3, 16'h0), 24, 0);
    push_rd("R8 coarse gain ch1", 24'h000002);
    xfer(mk(1, S_OF, 3'd0, 16'h0), 24, 0);
    push_rd("R8 fine gain ch3", 24'h0000A5);
    xfer(mk(1, S_DATA, 3'd4, 16'h0), 24, 0);
    push_rd("R8 offset ch0", 24'h007F00);
    xfer(mk(1, S_NONE, 3'd0, 16'h0), 24, 0);
    push_rd("R8 broadcast read gives ch0", 24'h005555);
    push_codes("R3 gain writes leave codes", cv4(16'h5555, 16'h6666, 16'h5555, 16'h5555));

    xfer(mk(0, S_FUNC, 3'd0, 16'h0001), 24, 0);
    xfer(mk(1, S_FUNC, 3'd0, 16'h0), 24, 0);
    xfer(mk(1, S_NONE, 3'd0, 16'h0), 24, 0);
    push_rd("R4 coding set to twos complement", 24'h000001);

    xfer(mk(0, S_DATA, 3'd0, 16'h0BAD), 23, 0);
    push_codes("R11 short frame", cv4(16'h5555, 16'h6666, 16'h5555, 16'h5555));
    xfer(mk(0, S_DATA, 3'd0, 16'h0BAD), 25, 0);
    push_codes("R11 long frame", cv4(16'h5555, 16'h6666, 16'h5555, 16'h5555));
    xfer(mk(0, S_DATA, 3'd0, 16'h0BAD) | 24'h400000, 24, 0);
    push_codes("R1 bit22 set ignored", cv4(16'h5555, 16'h6666, 16'h5555, 16'h5555));

    xfer(24'h04ABCD, 24, 0);
    push_codes("R7 software clear", {4{16'h0000}});
    xfer(mk(0, S_DATA, 3'd1, 16'h1111), 24, 0);
    push_codes("R5 only rewritten channel leaves clear", cv4(16'h0, 16'h1111, 16'h0, 16'h0));

    xfer(mk(0, S_FUNC, 3'd0, 16'h0000), 24, 0);
    @(negedge clk);
    clr_n = 1'b0;
    repeat (12) @(negedge clk);
    push_codes("R5 pin clear offset binary", {4{16'h0000}});
    xfer(mk(0, S_DATA, 3'd0, 16'h2222), 24, 0);
    push_codes("R5 write while pin low", cv4(16'h2222, 16'h0, 16'h0, 16'h0));
    @(negedge clk);
    clr_n = 1'b1;
    repeat (12) @(negedge clk);
    push_codes("R5 pin release holds", cv4(16'h2222, 16'h0, 16'h0, 16'h0));

    xfer(mk(0, S_DATA, 3'd4, 16'h3333), 24, 0);
    push_codes("R3 broadcast before collision", {4{16'h3333}});
    xfer(mk(0, S_DATA, 3'd3, 16'h4444), 24, 1);
    push_codes("R10 clear beats frame", {4{16'h0000}});
    @(negedge clk);
    clr_n = 1'b1;
    repeat (12) @(negedge clk);
    push_codes("R10 dropped write stays out", {4{16'h0000}});

    do_reset(1'b0);
    push_codes("R6 pin low at reset release", {4{16'h0000}});
    do_reset(1'b1);
    push_codes("R9 reset again", {4{16'h8000}});
    xfer(mk(1, S_FUNC, 3'd0, 16'h0), 24, 0);
    xfer(mk(1, S_NONE, 3'd0, 16'h0), 24, 0);
    push_rd("R4 coding reset to offset binary", 24'h000000);

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule